// File: doc/BRIEF.md
# Frame Alignment Offset Meter

This block measures how far a frame evaluation signal lags the frame pulse, with a resolution of half a master clock. Software arms a measurement by raising a start bit. The meter then waits for the next reference edge of the frame pulse, counts master clocks until the first matching edge of the evaluation signal, and records in which clock phase that edge fell. The result appears in a 16-bit status word, and a completion flag rises once the following reference edge has closed the window.

A mode input picks the edge polarity. In ST-BUS timing the falling edges of both signals are compared. In GCI timing the rising edges are compared. The result stays frozen until the start bit is lowered. Lowering the start bit clears the word, and raising it again starts a new cycle.

Top module: `frame_offset_meter`

## Requirements
- R1: A measurement is armed only by a low-to-high change of `startBit`. While it stays low, the status word reads zero. Matching evaluation edges that are sampled before the first reference edge after arming are ignored.
- R2: With `gciMode` = 0, the reference is a falling edge of `framePulse` and the matching evaluation edge is a falling edge of `evalIn`. Rising evaluation edges are ignored.
- R3: With `gciMode` = 1, the reference is a rising edge of `framePulse` and the matching evaluation edge is a rising edge of `evalIn`. Falling evaluation edges are ignored.
- R4: Bits 10..0 hold the offset as an unsigned binary number, with bit 10 as the MSB. Clock edges are numbered from 0, which is the edge where the new frame pulse level is first sampled. If the new evaluation level is first sampled at edge k ≥ 1, the offset is k.
- R5: Bit 11 is 1 when the matching evaluation transition occurred while the clock was high, that is, when it was already present at the falling clock edge before edge k. Bit 11 is 0 when the transition occurred while the clock was low.
- R6: Only the first matching evaluation edge in the window is recorded. Later matching edges in the window do not change the result.
- R7: The offset saturates at 2047.
- R8: Bit 12 is the completion flag. It rises one clock after the edge at which the second reference level after arming is sampled, and it reads 0 at that edge.
- R9: If no matching edge occurs in the window, the completion flag is still set, and bits 11..0 read zero.
- R10: Once the completion flag is set, further frame pulse and evaluation edges leave the status word unchanged while `startBit` stays high.
- R11: A high-to-low change of `startBit` clears bits 12..0. The cleared value appears one clock after the edge at which the low level is first sampled.
- R12: After reset the status word is zero. Bits 15..13 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| framePulse | input | 1 | Frame pulse |
| evalIn | input | 1 | Frame evaluation signal to be measured |
| gciMode | input | 1 | 0: falling-edge (ST-BUS) polarity, 1: rising-edge (GCI) polarity |
| startBit | input | 1 | Start control bit; a rise arms the meter, a fall clears it |
| statusWord | output | 16 | {3'b000, complete, phase, offset[10:0]} |

## Verification
The bench builds the meter with its default counter width of 11 bits. This puts the full 16-bit layout and the saturation point at 2047 within reach of a single window of about 2200 clocks. Evaluation edges are placed a quarter or three quarters of a clock into a cycle, which exercises both values of the phase bit at offsets from 1 up past saturation. Both edge polarities are driven, along with opposite-polarity decoy edges, edges that arrive before the window opens, a second matching edge, and a window with no edge at all.

// File: rtl/fam_pkg.sv
package fam_pkg;

  localparam int STATUS_W = 16;
  localparam int FIELD_W  = 11;

  typedef struct packed {
    logic clear;
    logic loadCnt;
    logic capture;
    logic setDone;
  } famStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAITREF = 2'd1,
    ST_MEASURE = 2'd2,
    ST_DONE    = 2'd3
  } famState_t;

endpackage

// File: rtl/fam_datapath.sv
module fam_datapath
  import fam_pkg::*;
#(
  parameter int DELAY_W = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                framePulse,
  input  logic                evalIn,
  input  logic                gciMode,
  input  famStrobe_t          strobeIn,
  output logic                refEdge,
  output logic                evalEdge,
  output logic [STATUS_W-1:0] statusWord
);

  localparam logic [DELAY_W-1:0] CNT_MAX = {DELAY_W{1'b1}};

  logic fpNorm, evNorm;
  logic fpQ, fpPrevQ;
  logic evQ, evPrevQ;
  logic evNegQ, evNegHoldQ;
  logic [DELAY_W-1:0] cntQ;
  logic [DELAY_W-1:0] delayQ;
  logic phaseQ;
  logic doneQ;
  logic [FIELD_W-1:0] delayField;

  // both polarities are folded so that the active edge is always a rise
  assign fpNorm = gciMode ? framePulse : ~framePulse;
  assign evNorm = gciMode ? evalIn : ~evalIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fpQ        <= 1'b0;
      fpPrevQ    <= 1'b0;
      evQ        <= 1'b0;
      evPrevQ    <= 1'b0;
      evNegHoldQ <= 1'b0;
    end else begin
      fpQ        <= fpNorm;
      fpPrevQ    <= fpQ;
      evQ        <= evNorm;
      evPrevQ    <= evQ;
      evNegHoldQ <= evNegQ;
    end
  end

  // mid-cycle sample tells which half of the clock the transition fell in
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) evNegQ <= 1'b0;
    else       evNegQ <= evNorm;
  end

  assign refEdge  = fpQ & ~fpPrevQ;
  assign evalEdge = evQ & ~evPrevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobeIn.clear) begin
      cntQ <= '0;
    end else if (strobeIn.loadCnt) begin
      cntQ <= DELAY_W'(1);
    end else if (cntQ != CNT_MAX) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayQ <= '0;
      phaseQ <= 1'b0;
      doneQ  <= 1'b0;
    end else if (strobeIn.clear) begin
      delayQ <= '0;
      phaseQ <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      if (strobeIn.capture) begin
        delayQ <= cntQ;
        phaseQ <= evNegHoldQ;
      end
      if (strobeIn.setDone) doneQ <= 1'b1;
    end
  end

  assign delayField = FIELD_W'(delayQ);
  assign statusWord = {3'b000, doneQ, phaseQ, delayField};

  // R8
  done_after_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(refEdge));

  // R10
  frozen_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !strobeIn.clear) |=> ($stable(delayQ) && $stable(phaseQ)));

endmodule

// File: rtl/fam_control.sv
module fam_control
  import fam_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startBit,
  input  logic       refEdge,
  input  logic       evalEdge,
  output famStrobe_t strobeOut
);

  famState_t stateQ, stateNext;
  logic startQ, startPrevQ;
  logic startRise, startFall;
  logic capturedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ     <= 1'b0;
      startPrevQ <= 1'b0;
    end else begin
      startQ     <= startBit;
      startPrevQ <= startQ;
    end
  end

  assign startRise = startQ & ~startPrevQ;
  assign startFall = ~startQ & startPrevQ;

  always_comb begin
    strobeOut = '0;
    stateNext = stateQ;
    if (startFall) begin
      strobeOut.clear = 1'b1;
      stateNext       = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startRise) begin
            strobeOut.clear = 1'b1;
            stateNext       = ST_WAITREF;
          end
        end
        ST_WAITREF: begin
          if (refEdge) begin
            strobeOut.loadCnt = 1'b1;
            stateNext         = ST_MEASURE;
          end
        end
        ST_MEASURE: begin
          if (refEdge) begin
            strobeOut.setDone = 1'b1;
            stateNext         = ST_DONE;
          end else if (evalEdge && !capturedQ) begin
            strobeOut.capture = 1'b1;
          end
        end
        default: stateNext = ST_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      capturedQ <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (strobeOut.clear || strobeOut.loadCnt) capturedQ <= 1'b0;
      else if (strobeOut.capture)               capturedQ <= 1'b1;
    end
  end

  // R6
  single_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (capturedQ && !strobeOut.clear && !strobeOut.loadCnt) |-> !strobeOut.capture);

endmodule

// File: rtl/frame_offset_meter.sv
module frame_offset_meter
  import fam_pkg::*;
#(
  parameter int DELAY_W = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        framePulse,
  input  logic        evalIn,
  input  logic        gciMode,
  input  logic        startBit,
  output logic [15:0] statusWord
);

  famStrobe_t strobe;
  logic refEdge;
  logic evalEdge;

  fam_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .startBit  (startBit),
    .refEdge   (refEdge),
    .evalEdge  (evalEdge),
    .strobeOut (strobe)
  );

  fam_datapath #(.DELAY_W(DELAY_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .evalIn     (evalIn),
    .gciMode    (gciMode),
    .strobeIn   (strobe),
    .refEdge    (refEdge),
    .evalEdge   (evalEdge),
    .statusWord (statusWord)
  );

  // R11
  clear_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startBit) |=> ##1 (statusWord[12:0] == 13'd0));

  // R1
  idle_when_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!startBit && $past(!startBit)) |=> (statusWord == 16'd0));

endmodule

// File: tb/test_frame_offset_meter.sv
module test_frame_offset_meter;

  localparam int PERIOD = 20;
  localparam int Q      = PERIOD / 4;

  logic        clk = 1'b0;
  logic        rstN;
  logic        framePulse;
  logic        evalIn;
  logic        gciMode;
  logic        startBit;
  logic [15:0] statusWord;

  int checks   = 0;
  int failures = 0;

  frame_offset_meter i_frame_offset_meter (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .evalIn     (evalIn),
    .gciMode    (gciMode),
    .startBit   (startBit),
    .statusWord (statusWord)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [15:0] expWord(input bit done, input bit ph, input int d);
    logic [10:0] dv;
    dv = d[10:0];
    return {3'b000, done, ph, dv};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic armUnit(input bit gci);
    gciMode    = gci;
    startBit   = 1'b0;
    framePulse = gci ? 1'b0 : 1'b1;
    evalIn     = gci ? 1'b0 : 1'b1;
    repeat (4) @(posedge clk);
    #(Q) startBit = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  // one window: reference at c=0, closing reference at c=frameLen
  task automatic measureCase(input string req, input bit gci, input int m, input bit high,
                             input int frameLen, input int decoyAt, input int m2,
                             input bit early, input int expDelay, input bit expPhase);
    logic fpAct, evPre;
    fpAct = gci ? 1'b1 : 1'b0;
    evPre = gci ? 1'b0 : 1'b1;
    armUnit(gci);
    if (early) begin
      @(posedge clk); #(Q) evalIn = ~evPre;
      @(posedge clk); #(Q) evalIn = evPre;
      repeat (2) @(posedge clk);
    end
    for (int c = 0; c <= frameLen + 2; c++) begin
      @(posedge clk);
      #(Q);
      if (c == 0)            framePulse = fpAct;
      if (c == 1)            framePulse = ~fpAct;
      if (c == frameLen)     framePulse = fpAct;
      if (c == frameLen + 1) framePulse = ~fpAct;
      if (decoyAt >= 0 && c == 0) evalIn = ~evPre;
      if (c == decoyAt)      evalIn = evPre;
      if (c == m && high)    evalIn = ~evPre;
      if (m2 > m && c == m2)     evalIn = evPre;
      if (m2 > m && c == m2 + 1) evalIn = ~evPre;
      #(2*Q);
      if (c == m && !high)   evalIn = ~evPre;
      if (c == frameLen + 1) check({req, " R8 before"}, statusWord, expWord(1'b0, expPhase, expDelay));
      if (c == frameLen + 2) check({req, " R8 after"},  statusWord, expWord(1'b1, expPhase, expDelay));
    end
  endtask

  task automatic noRiseCase();
    gciMode = 1'b0; startBit = 1'b0; framePulse = 1'b1; evalIn = 1'b1;
    @(posedge clk); #(Q) framePulse = 1'b0;
    @(posedge clk); #(Q) framePulse = 1'b1;
    repeat (3) @(posedge clk);
    #(Q) evalIn = 1'b0;
    repeat (4) @(posedge clk);
    #(Q) framePulse = 1'b0;
    @(posedge clk); #(Q) framePulse = 1'b1;
    repeat (3) @(posedge clk);
    #(3*Q) check("R1 no rise", statusWord, 16'h0000);
  endtask

  task automatic freezeCase(input logic [15:0] held);
    @(posedge clk); #(Q) evalIn = 1'b1; framePulse = 1'b0;
    @(posedge clk); #(Q) framePulse = 1'b1;
    repeat (3) @(posedge clk);
    #(Q) evalIn = 1'b0;
    repeat (3) @(posedge clk);
    #(Q) framePulse = 1'b0;
    @(posedge clk); #(Q) framePulse = 1'b1;
    repeat (4) @(posedge clk);
    #(3*Q) check("R10 frozen", statusWord, held);
  endtask

  task automatic clearCase(input logic [15:0] held);
    @(posedge clk); #(Q) startBit = 1'b0;
    @(posedge clk); #(3*Q) check("R11 not yet", statusWord, held);
    @(posedge clk); #(3*Q) check("R11 cleared", statusWord, 16'h0000);
  endtask

  initial begin
    rstN = 1'b0; startBit = 1'b0; gciMode = 1'b0; framePulse = 1'b1; evalIn = 1'b1;
    repeat (3) @(posedge clk);
    #(3*Q) check("R12 reset", statusWord, 16'h0000);
    #(Q) rstN = 1'b1;
    repeat (2) @(posedge clk);
    #(3*Q) check("R12 after reset", statusWord, 16'h0000);

    noRiseCase();
    measureCase("R2 R4 R5 st high",     1'b0, 5,    1'b1, 20,   -1, -1, 1'b0, 5,    1'b1);
    measureCase("R4 R5 st low",         1'b0, 12,   1'b0, 20,   -1, -1, 1'b0, 12,   1'b0);
    measureCase("R2 st decoy",          1'b0, 9,    1'b0, 16,   3,  -1, 1'b0, 9,    1'b0);
    measureCase("R3 gci decoy",         1'b1, 7,    1'b1, 16,   2,  -1, 1'b0, 7,    1'b1);
    measureCase("R3 R4 gci min",        1'b1, 1,    1'b0, 10,   -1, -1, 1'b0, 1,    1'b0);
    measureCase("R6 first edge",        1'b0, 4,    1'b1, 16,   -1, 8,  1'b0, 4,    1'b1);
    measureCase("R1 early edge",        1'b0, 6,    1'b0, 14,   -1, -1, 1'b1, 6,    1'b0);
    measureCase("R9 no edge",           1'b0, -1,   1'b0, 12,   -1, -1, 1'b0, 0,    1'b0);
    measureCase("R7 saturate",          1'b0, 2100, 1'b0, 2200, -1, -1, 1'b0, 2047, 1'b0);
    freezeCase(expWord(1'b1, 1'b0, 2047));
    clearCase(expWord(1'b1, 1'b0, 2047));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog R12 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule